// File: doc/BRIEF.md
# Page Write-Protection Controller with Keyed Erase Enable

This block guards a 32-page on-chip SRAM against stray writes. Each page has one protection flag. Software can raise a flag at any time, but only a reset lowers it. Every SRAM access request passes through the block, which grants it or suppresses it in the same cycle. When a write aimed at a protected page is suppressed, the block raises a violation pulse one cycle later. Reads are always let through.

A separate erase-enable control bit is shielded by a two-value key sequence held in a small state machine. The states are `KEY_LOCKED`, `KEY_ARMED` and `KEY_OPEN`. From `KEY_LOCKED`, writing key 0xCA moves the machine to `KEY_ARMED`. From there, writing key 0x53 moves it to `KEY_OPEN`; any other key value returns it to `KEY_LOCKED`, except 0xCA, which restarts the sequence in `KEY_ARMED`. In `KEY_OPEN`, the next key write goes to `KEY_ARMED` if it is 0xCA and to `KEY_LOCKED` otherwise, and a control-register write also returns the machine to `KEY_LOCKED`.

The block also holds a sticky fault-routing bit. Once it is set, a processor lockup input is copied onto a group of break outputs. While it is clear, the break outputs stay low. A simple register port (address, write data, write strobe and combinational read data) gives access to the control, protection and key registers.

Top module: `sram_guard`

## Requirements
- R1: After reset, the registers at 0x18, 0x20 and 0x24 all read 0, `erase_en` is 0, `brk_out` is 0 whatever `fault_in` is, and the key machine is in `KEY_LOCKED`.
- R2: A write to the protection register at 0x20 ORs write-data bit x into page flag x. Writing 0 to a bit leaves that bit unchanged. Only reset clears a flag. A read of 0x20 returns the 32 flags.
- R3: A write request (`sram_valid`=1, `sram_we`=1) whose page index `sram_addr[14:10]` selects a set flag gives `sram_grant`=0 in the same cycle. A write to a page whose flag is clear gives `sram_grant`=1.
- R4: Each suppressed write request gives `viol_pulse`=1 in the following cycle, and only in that cycle. Read requests (`sram_we`=0) are always granted and never raise `viol_pulse`.
- R5: The key register at 0x24 always reads 0. Only write-data bits 7:0 form the key; bits 31:8 are ignored.
- R6: The machine reaches `KEY_OPEN` only when a key write of 0x53 directly follows a key write of 0xCA. Writes to other registers in between do not break the sequence.
- R7: A key write of a wrong value in any state returns the machine to `KEY_LOCKED`. A key write of 0xCA in any state, including `KEY_ARMED`, moves it to `KEY_ARMED`.
- R8: Control bit 0 at 0x18 is `erase_en`. A control write loads this bit, set or clear, only in `KEY_OPEN`, and that control write also returns the machine to `KEY_LOCKED`. In every other state a control write leaves `erase_en` unchanged.
- R9: Control bit 1 at 0x18 is the route enable. A control write can set it in any key state; writing 0 to it has no effect, and only reset clears it. While it is set, every bit of `brk_out` equals `fault_in`; while it is clear, `brk_out` is 0. A read of 0x18 returns {route enable, `erase_en`} in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data (combinational) |
| sram_valid | input | 1 | SRAM access request present |
| sram_we | input | 1 | Request is a write |
| sram_addr | input | 15 | SRAM byte address of the request |
| sram_grant | output | 1 | Request allowed to proceed |
| viol_pulse | output | 1 | One-cycle flag for a suppressed write |
| erase_en | output | 1 | Erase enable control bit |
| fault_in | input | 1 | Processor lockup/fault indication |
| brk_out | output | 6 | Break outputs driven from the fault input |

## Verification
A protection-register write and an SRAM write request to the same page can occur in the same cycle. The bench drives the flag-setting write to 0x20 and a write request to page 31 together and holds the request. The expected result is that the request is granted in that first cycle, because the grant is decided from the flags before the update. The request must then be refused in the next cycle, with `viol_pulse` high only in the cycle after that refusal.

// File: rtl/guard_pkg.sv
package guard_pkg;
    localparam logic [7:0] OFS_CTRL = 8'h18;
    localparam logic [7:0] OFS_PROT = 8'h20;
    localparam logic [7:0] OFS_KEY  = 8'h24;

    localparam logic [7:0] KEY_FIRST  = 8'hCA;
    localparam logic [7:0] KEY_SECOND = 8'h53;

    typedef enum logic [1:0] {
        KEY_LOCKED = 2'd0,
        KEY_ARMED  = 2'd1,
        KEY_OPEN   = 2'd2
    } key_state_t;
endpackage

// File: rtl/guard_key_fsm.sv
module guard_key_fsm
    import guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_val,
    input  logic       ctrl_wr,
    output logic       unlock_open
);
    key_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KEY_LOCKED;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_LOCKED: begin
                if (key_wr && key_val == KEY_FIRST) state_d = KEY_ARMED;
            end
            KEY_ARMED: begin
                if (key_wr) begin
                    if (key_val == KEY_SECOND)     state_d = KEY_OPEN;
                    else if (key_val == KEY_FIRST) state_d = KEY_ARMED;
                    else                           state_d = KEY_LOCKED;
                end
            end
            KEY_OPEN: begin
                if (key_wr)
                    state_d = (key_val == KEY_FIRST) ? KEY_ARMED : KEY_LOCKED;
                else if (ctrl_wr)
                    state_d = KEY_LOCKED;
            end
            default: state_d = KEY_LOCKED;
        endcase
    end

    // Outputs
    always_comb begin
        unlock_open = (state_q == KEY_OPEN);
    end
endmodule

// File: rtl/guard_prot_bank.sv
module guard_prot_bank #(
    parameter int PAGES    = 32,
    parameter int ADDR_W   = 15,
    parameter int PAGE_LSB = 10
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             set_wr,
    input  logic [PAGES-1:0]                 set_mask,
    input  logic                             req_valid,
    input  logic                             req_we,
    input  logic [ADDR_W-1:PAGE_LSB]         req_page_bits,
    output logic [PAGES-1:0]                 prot_q,
    output logic                             grant,
    output logic                             viol
);
    localparam int PIW = $clog2(PAGES);

    logic [PIW-1:0] page_idx;
    logic           hit_prot;
    logic           blocked;

    assign page_idx = req_page_bits[PAGE_LSB +: PIW];
    assign hit_prot = prot_q[page_idx];
    assign blocked  = req_valid && req_we && hit_prot;
    assign grant    = req_valid && !blocked;

    generate
        if (ADDR_W > PAGE_LSB + PIW) begin : g_hi_unused
            logic unused_hi;
            assign unused_hi = ^req_page_bits[ADDR_W-1:PAGE_LSB+PIW];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= '0;
            viol   <= 1'b0;
        end else begin
            if (set_wr) prot_q <= prot_q | set_mask;
            viol <= blocked;
        end
    end
endmodule

// File: rtl/guard_fault_route.sv
module guard_fault_route #(
    parameter int NBRK = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic            fault_in,
    output logic            route_q,
    output logic [NBRK-1:0] brk_out
);
    always_ff @(posedge clk) begin
        if (!rst_n)      route_q <= 1'b0;
        else if (set_en) route_q <= 1'b1;
    end

    generate
        for (genvar i = 0; i < NBRK; i++) begin : g_brk
            assign brk_out[i] = route_q & fault_in;
        end
    endgenerate
endmodule

// File: rtl/sram_guard.sv
module sram_guard
    import guard_pkg::*;
#(
    parameter int PAGES    = 32,
    parameter int ADDR_W   = 15,
    parameter int PAGE_LSB = 10,
    parameter int NBRK     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_we,
    output logic [31:0]       reg_rdata,
    input  logic              sram_valid,
    input  logic              sram_we,
    input  logic [ADDR_W-1:0] sram_addr,
    output logic              sram_grant,
    output logic              viol_pulse,
    output logic              erase_en,
    input  logic              fault_in,
    output logic [NBRK-1:0]   brk_out
);
    logic             wr_ctrl, wr_prot, wr_key;
    logic             unlock_open;
    logic             route_q;
    logic [PAGES-1:0] prot_q;
    logic [31:0]      prot_ext;
    logic             unused_addr_lo;

    assign wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
    assign wr_prot = reg_we && (reg_addr == OFS_PROT);
    assign wr_key  = reg_we && (reg_addr == OFS_KEY);
    assign unused_addr_lo = ^sram_addr[PAGE_LSB-1:0];

    guard_key_fsm u_key (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_wr      (wr_key),
        .key_val     (reg_wdata[7:0]),
        .ctrl_wr     (wr_ctrl),
        .unlock_open (unlock_open)
    );

    guard_prot_bank #(
        .PAGES    (PAGES),
        .ADDR_W   (ADDR_W),
        .PAGE_LSB (PAGE_LSB)
    ) u_prot (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_wr        (wr_prot),
        .set_mask      (reg_wdata[PAGES-1:0]),
        .req_valid     (sram_valid),
        .req_we        (sram_we),
        .req_page_bits (sram_addr[ADDR_W-1:PAGE_LSB]),
        .prot_q        (prot_q),
        .grant         (sram_grant),
        .viol          (viol_pulse)
    );

    guard_fault_route #(.NBRK(NBRK)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (wr_ctrl && reg_wdata[1]),
        .fault_in (fault_in),
        .route_q  (route_q),
        .brk_out  (brk_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                      erase_en <= 1'b0;
        else if (wr_ctrl && unlock_open) erase_en <= reg_wdata[0];
    end

    always_comb begin
        prot_ext = '0;
        prot_ext[PAGES-1:0] = prot_q;
    end

    always_comb begin
        unique case (reg_addr)
            OFS_CTRL: reg_rdata = {30'd0, route_q, erase_en};
            OFS_PROT: reg_rdata = prot_ext;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sram_guard_chk.sv
module sram_guard_chk #(
    parameter int PAGES    = 32,
    parameter int ADDR_W   = 15,
    parameter int PAGE_LSB = 10,
    parameter int NBRK     = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              reg_we,
    input logic [31:0]       reg_rdata,
    input logic              sram_valid,
    input logic              sram_we,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_grant,
    input logic              viol_pulse,
    input logic              erase_en,
    input logic              fault_in,
    input logic [NBRK-1:0]   brk_out,
    input logic [PAGES-1:0]  prot_bits,
    input logic              route_en,
    input logic              key_open
);
    localparam int PIW = $clog2(PAGES);

    logic wr_blocked;
    assign wr_blocked = sram_valid && sram_we
                        && prot_bits[sram_addr[PAGE_LSB +: PIW]];

    p_prot_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((prot_bits & $past(prot_bits)) == $past(prot_bits)));

    p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blocked |-> !sram_grant);

    p_viol_after_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_valid && sram_we && !sram_grant) |=> viol_pulse);

    p_viol_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> $past(sram_valid && sram_we && !sram_grant));

    p_read_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_valid && !sram_we) |-> sram_grant);

    p_key_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h24) |-> (reg_rdata == 32'd0));

    p_open_needs_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_open) |-> $past(reg_we && reg_addr == 8'h24
                                  && reg_wdata[7:0] == 8'h53));

    p_erase_guarded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !key_open |=> $stable(erase_en));

    p_brk_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !route_en |-> (brk_out == '0));

    p_brk_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        route_en |-> (brk_out == {NBRK{fault_in}}));

    p_route_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        route_en |=> route_en);
endmodule

bind sram_guard sram_guard_chk #(
    .PAGES    (PAGES),
    .ADDR_W   (ADDR_W),
    .PAGE_LSB (PAGE_LSB),
    .NBRK     (NBRK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .reg_rdata  (reg_rdata),
    .sram_valid (sram_valid),
    .sram_we    (sram_we),
    .sram_addr  (sram_addr),
    .sram_grant (sram_grant),
    .viol_pulse (viol_pulse),
    .erase_en   (erase_en),
    .fault_in   (fault_in),
    .brk_out    (brk_out),
    .prot_bits  (prot_q),
    .route_en   (route_q),
    .key_open   (unlock_open)
);

// File: tb/sram_guard_tb_top.sv
`timescale 1ns/1ps
module sram_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_we;
    logic [31:0] reg_rdata;
    logic        sram_valid, sram_we;
    logic [14:0] sram_addr;
    logic        sram_grant, viol_pulse, erase_en, fault_in;
    logic [5:0]  brk_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    sram_guard dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .sram_valid(sram_valid),
        .sram_we(sram_we), .sram_addr(sram_addr), .sram_grant(sram_grant),
        .viol_pulse(viol_pulse), .erase_en(erase_en), .fault_in(fault_in),
        .brk_out(brk_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive a register write for one cycle; returns at the following negedge.
    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(8'h18, v); check("R1 ctrl", v, 0);
        reg_read(8'h20, v); check("R1 prot", v, 0);
        reg_read(8'h24, v); check("R1 key", v, 0);
        check("R1 erase_en", {31'd0, erase_en}, 0);
        fault_in = 1'b1; #1;
        check("R1 brk", {26'd0, brk_out}, 0);
        fault_in = 1'b0;
        sram_valid = 1'b1; sram_we = 1'b1; sram_addr = 15'h0000; #1;
        check("R1 grant page0", {31'd0, sram_grant}, 1);
        sram_valid = 1'b0; sram_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_prot_set();
        logic [31:0] v;
        reg_write(8'h20, 32'h0000_0005);
        reg_read(8'h20, v); check("R2 set", v, 32'h5);
        reg_write(8'h20, 32'h0000_0100);
        reg_read(8'h20, v); check("R2 or", v, 32'h105);
        reg_write(8'h20, 32'h0);
        reg_read(8'h20, v); check("R2 zero keeps", v, 32'h105);
    endtask

    task automatic t_grant();
        sram_valid = 1'b1; sram_we = 1'b1;
        sram_addr = 15'h0800; #1;
        check("R3 page2 blocked", {31'd0, sram_grant}, 0);
        sram_addr = 15'h07FF; #1;
        check("R3 page1 granted", {31'd0, sram_grant}, 1);
        sram_addr = 15'h2000; #1;
        check("R3 page8 blocked", {31'd0, sram_grant}, 0);
        sram_addr = 15'h0800;
        @(negedge clk);
        sram_valid = 1'b0; sram_we = 1'b0;
        check("R4 viol pulse", {31'd0, viol_pulse}, 1);
        @(negedge clk);
        check("R4 viol single", {31'd0, viol_pulse}, 0);
        sram_valid = 1'b1; sram_we = 1'b0; sram_addr = 15'h0800; #1;
        check("R4 read granted", {31'd0, sram_grant}, 1);
        @(negedge clk);
        sram_valid = 1'b0;
        check("R4 read no viol", {31'd0, viol_pulse}, 0);
    endtask

    task automatic t_same_cycle();
        sram_valid = 1'b1; sram_we = 1'b1; sram_addr = 15'h7C00;
        reg_addr = 8'h20; reg_wdata = 32'h8000_0000; reg_we = 1'b1; #1;
        check("R3 same-cycle grant", {31'd0, sram_grant}, 1);
        @(negedge clk);
        reg_we = 1'b0;
        check("R4 no viol for granted", {31'd0, viol_pulse}, 0);
        check("R3 next-cycle block", {31'd0, sram_grant}, 0);
        @(negedge clk);
        sram_valid = 1'b0; sram_we = 1'b0;
        check("R4 viol after block", {31'd0, viol_pulse}, 1);
        @(negedge clk);
    endtask

    task automatic t_key_unlock();
        logic [31:0] v;
        reg_write(8'h24, 32'hFFFF_FFCA);
        reg_read(8'h24, v); check("R5 key reads zero", v, 0);
        reg_write(8'h20, 32'h0);              // non-key write between steps
        reg_write(8'h24, 32'h0000_0053);
        reg_write(8'h18, 32'h1);
        check("R6 unlock erase set", {31'd0, erase_en}, 1);
        reg_write(8'h18, 32'h0);
        check("R8 relock keeps erase", {31'd0, erase_en}, 1);
        reg_write(8'h24, 32'hCA);
        reg_write(8'h24, 32'h53);
        reg_write(8'h18, 32'h0);
        check("R8 open clears erase", {31'd0, erase_en}, 0);
    endtask

    task automatic t_wrong_key();
        reg_write(8'h24, 32'hCA);
        reg_write(8'h24, 32'h11);
        reg_write(8'h24, 32'h53);
        reg_write(8'h18, 32'h1);
        check("R7 wrong middle key", {31'd0, erase_en}, 0);
        reg_write(8'h24, 32'hCA);
        reg_write(8'h24, 32'hCA);
        reg_write(8'h24, 32'h53);
        reg_write(8'h24, 32'h00);
        reg_write(8'h18, 32'h1);
        check("R7 wrong key after open", {31'd0, erase_en}, 0);
        reg_write(8'h24, 32'hCA);
        reg_write(8'h24, 32'hCA);
        reg_write(8'h24, 32'h53);
        reg_write(8'h18, 32'h1);
        check("R7 repeated first key rearms", {31'd0, erase_en}, 1);
    endtask

    task automatic t_route();
        logic [31:0] v;
        fault_in = 1'b1; #1;
        check("R9 brk quiet", {26'd0, brk_out}, 0);
        reg_write(8'h18, 32'h2);
        #1 check("R9 brk follows high", {26'd0, brk_out}, 32'h3F);
        fault_in = 1'b0; #1;
        check("R9 brk follows low", {26'd0, brk_out}, 0);
        reg_write(8'h18, 32'h0);
        reg_read(8'h18, v); check("R9 route sticky", v, 32'h3);
        fault_in = 1'b1; #1;
        check("R9 brk still routed", {26'd0, brk_out}, 32'h3F);
    endtask

    task automatic t_final_reset();
        logic [31:0] v;
        do_reset();
        reg_read(8'h20, v); check("R2 reset clears prot", v, 0);
        reg_read(8'h18, v); check("R9 reset clears route", v, 0);
        #1 check("R9 brk after reset", {26'd0, brk_out}, 0);
    endtask

    initial begin
        rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_we = 1'b0;
        sram_valid = 1'b0; sram_we = 1'b0; sram_addr = '0; fault_in = 1'b0;
        @(negedge clk);
        do_reset();
        t_reset();
        t_prot_set();
        t_grant();
        t_same_cycle();
        t_key_unlock();
        t_wrong_key();
        t_route();
        t_final_reset();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule